// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits beside a receive path and decides, while the first six bytes of a frame stream past, whether the frame's destination address is one the station wants. A frame is taken when any of four paths allows it: an exact match against the station's own address, the all-ones broadcast address, a group address whose hash lands on a set bit of a 64-bit table, or promiscuous mode.

The address bytes arrive one per cycle on a byte stream, marked as the first byte by a start flag. A running CRC-32 over the six bytes gives the hash index. One cycle after the sixth byte, the block raises a one-cycle decision pulse. The pulse carries the accept verdict, a group-address flag, and two exclusive outcomes. One says the frame should be stored. The other says it was accepted while the receiver only watches, and so is counted as missed.

Top module: `addr_filter`

## Requirements
- R1: For a byte taken as the sixth address byte, `dec_valid` is high for exactly the one cycle that follows, and is low at all other times.
- R2: With promiscuous and group paths out of play, a unicast address is accepted only when all six bytes equal the station address; byte k on the wire is compared with `station_addr[8k+7:8k]`.
- R3: The all-ones address is accepted when the broadcast-enable bit (`rx_cfg` bit 2) is set and rejected otherwise, whatever the hash table holds.
- R4: A group address has bit 0 of its first byte set and is not all ones. It is accepted when the multicast-enable bit (`rx_cfg` bit 3) is set and the table bit selected by its hash is set. The CRC is a reflected CRC-32 with polynomial 0xEDB88320, preset to all ones, fed each byte least significant bit first, with no final inversion. The hash index n is CRC bits 5..0 in reverse order (CRC bit 0 becomes index bit 5). Bit n is `hash_table[8*(n/8) + n%8]`.
- R5: With the promiscuous bit (`rx_cfg` bit 4) set, every address is accepted.
- R6: `dec_group` on each decision equals bit 0 of the first address byte.
- R7: With the monitor bit (`rx_cfg` bit 5) set, an accepted address gives `dec_missed` = 1 and `dec_store` = 0. With it clear, `dec_store` equals `dec_accept` and `dec_missed` is 0.
- R8: `rx_cfg` bits 0 and 1 (keep errored frames, keep short frames) have no effect on any decision output.
- R9: A byte with `in_first` set always restarts the address at byte 0, even in the middle of an address. Bytes without `in_first` that arrive after a completed address are ignored and produce no decision.
- R10: While reset is held, and after its release until a decision, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_cfg | input | 6 | Receive mode bits |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| hash_table | input | 64 | Group hash table, eight bytes |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_first | input | 1 | The byte is the first destination byte |
| in_data | input | 8 | Destination address byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Address accepted |
| dec_group | output | 1 | Group (multicast or broadcast) address |
| dec_store | output | 1 | Accepted and to be stored |
| dec_missed | output | 1 | Accepted while monitoring, counted as missed |

## Verification
Two functions can fall in the same cycle. The restart on a start-flagged byte can coincide with the completion of an address. The group-address check can coincide with a station match, so that promiscuous, monitor and hash outcomes all resolve on the same decision. The bench provokes the first case by cutting an address short with a new start flag, and by sending bare bytes after a completed address. It judges the case by whether a decision pulse appears only after the restarted sixth byte. The second case is provoked by vectors that combine promiscuous and monitor bits with group and station addresses. Each is checked against verdicts computed from the requirements, including the CRC hash computed separately in the bench.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int BYTE_W     = 8;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
  localparam int HASH_BITS  = 64;
  localparam int HASH_IDX_W = $clog2(HASH_BITS);
  localparam int CFG_W      = 6;

  localparam int CFG_BCAST = 2;
  localparam int CFG_MCAST = 3;
  localparam int CFG_PROM  = 4;
  localparam int CFG_MON   = 5;

  typedef struct packed {
    logic valid;
    logic accept;
    logic group;
    logic store;
    logic missed;
  } decision_t;
endpackage

// File: rtl/af_crc_byte.sv
module af_crc_byte #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crc_in;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      logic fb;
      assign fb = stage[gi][0] ^ data[gi];
      assign stage[gi+1] = fb ? ((stage[gi] >> 1) ^ POLY) : (stage[gi] >> 1);
    end
  endgenerate

  assign crc_out = stage[DATA_W];
endmodule

// File: rtl/af_hash_lookup.sv
module af_hash_lookup #(
  parameter int TABLE_BITS = 64,
  localparam int IDX_W = $clog2(TABLE_BITS)
) (
  input  logic [IDX_W-1:0]      crc_low,
  input  logic [TABLE_BITS-1:0] table_bits,
  output logic [IDX_W-1:0]      index,
  output logic                  hit
);
  genvar gi;
  generate
    for (gi = 0; gi < IDX_W; gi++) begin : g_rev
      assign index[gi] = crc_low[IDX_W-1-gi];
    end
  endgenerate

  assign hit = table_bits[index];
endmodule

// File: rtl/af_addr_track.sv
module af_addr_track
  import addr_filter_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES,
  localparam int CNT_W = $clog2(NBYTES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBYTES*BYTE_W-1:0] station,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic [BYTE_W-1:0]        in_data,
  output logic                     done,
  output logic                     match_fin,
  output logic                     ones_fin,
  output logic                     group_fin,
  output logic [HASH_IDX_W-1:0]    crc_low_fin
);
  logic [BYTE_W-1:0] sta_b [NBYTES];

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_sta
      assign sta_b[gi] = station[gi*BYTE_W +: BYTE_W];
    end
  endgenerate

  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic             active_q, active_d;
  logic [CRC_W-1:0] crc_q, crc_d, crc_src, crc_nx;
  logic             match_q, match_d, match_nx;
  logic             ones_q, ones_d, ones_nx;
  logic             group_q, group_d, group_nx;
  logic             take, last;

  af_crc_byte #(.CRC_W(CRC_W), .DATA_W(BYTE_W), .POLY(CRC_POLY)) u_crc (
    .crc_in (crc_src),
    .data   (in_data),
    .crc_out(crc_nx)
  );

  always_comb begin
    idx      = in_first ? '0 : cnt_q;
    take     = in_valid && (in_first || active_q);
    last     = take && (idx == CNT_W'(NBYTES-1));
    crc_src  = in_first ? '1 : crc_q;
    match_nx = (in_first ? 1'b1 : match_q) && (in_data == sta_b[idx]);
    ones_nx  = (in_first ? 1'b1 : ones_q) && (&in_data);
    group_nx = in_first ? in_data[0] : group_q;

    cnt_d    = cnt_q;
    active_d = active_q;
    crc_d    = crc_q;
    match_d  = match_q;
    ones_d   = ones_q;
    group_d  = group_q;
    if (take) begin
      cnt_d    = last ? '0 : idx + CNT_W'(1);
      active_d = !last;
      crc_d    = crc_nx;
      match_d  = match_nx;
      ones_d   = ones_nx;
      group_d  = group_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      crc_q    <= '1;
      match_q  <= 1'b0;
      ones_q   <= 1'b0;
      group_q  <= 1'b0;
    end else if (take) begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      crc_q    <= crc_d;
      match_q  <= match_d;
      ones_q   <= ones_d;
      group_q  <= group_d;
    end
  end

  assign done        = last;
  assign match_fin   = match_nx;
  assign ones_fin    = ones_nx;
  assign group_fin   = group_nx;
  assign crc_low_fin = crc_nx[HASH_IDX_W-1:0];

  // R9: the byte counter never leaves the address range
  a_r9_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(NBYTES));

  // R9: a completed address leaves the tracker idle and rewound
  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!active_q && cnt_q == '0));
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import addr_filter_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CFG_W-1:0]             rx_cfg,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
  input  logic [HASH_BITS-1:0]         hash_table,
  input  logic                         in_valid,
  input  logic                         in_first,
  input  logic [BYTE_W-1:0]            in_data,
  output logic                         dec_valid,
  output logic                         dec_accept,
  output logic                         dec_group,
  output logic                         dec_store,
  output logic                         dec_missed
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                  done, match_fin, ones_fin, group_fin;
  logic [HASH_IDX_W-1:0] crc_low, hash_idx;
  logic                  hash_hit;

  af_addr_track #(.NBYTES(ADDR_BYTES)) u_track (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .station    (station_addr),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_data    (in_data),
    .done       (done),
    .match_fin  (match_fin),
    .ones_fin   (ones_fin),
    .group_fin  (group_fin),
    .crc_low_fin(crc_low)
  );

  af_hash_lookup #(.TABLE_BITS(HASH_BITS)) u_hash (
    .crc_low   (crc_low),
    .table_bits(hash_table),
    .index     (hash_idx),
    .hit       (hash_hit)
  );

  logic unused_cfg_bits;
  logic unused_hash_idx;
  assign unused_cfg_bits = ^rx_cfg[1:0];
  assign unused_hash_idx = ^hash_idx;

  decision_t dec_q, dec_d;
  logic      accept_nx;

  always_comb begin
    if (rx_cfg[CFG_PROM])
      accept_nx = 1'b1;
    else if (ones_fin)
      accept_nx = rx_cfg[CFG_BCAST];
    else if (group_fin)
      accept_nx = rx_cfg[CFG_MCAST] && hash_hit;
    else
      accept_nx = match_fin;

    dec_d = '0;
    if (done) begin
      dec_d.valid  = 1'b1;
      dec_d.accept = accept_nx;
      dec_d.group  = group_fin;
      dec_d.store  = accept_nx && !rx_cfg[CFG_MON];
      dec_d.missed = accept_nx && rx_cfg[CFG_MON];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) dec_q <= '0;
    else            dec_q <= dec_d;
  end

  assign dec_valid  = dec_q.valid;
  assign dec_accept = dec_q.accept;
  assign dec_group  = dec_q.group;
  assign dec_store  = dec_q.store;
  assign dec_missed = dec_q.missed;

  // R1: decision pulse lasts a single cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    dec_valid |=> !dec_valid);

  // R1: decision follows the last address byte
  a_r1_follows_done: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> dec_valid);

  // R10: no verdict outside the pulse
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dec_valid |-> !(dec_accept || dec_group || dec_store || dec_missed));

  // R7: store and missed never together, each implies accept
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(dec_store && dec_missed) && ((dec_store || dec_missed) == dec_accept));

  // R5: promiscuous on the last byte forces acceptance
  a_r5_prom: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && rx_cfg[CFG_PROM]) |=> dec_accept);
endmodule

// File: tb/test_addr_filter.sv
module test_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rx_cfg = '0;
  logic [47:0] station_addr = 48'h5544_3322_1102;
  logic [63:0] hash_table = '0;
  logic        in_valid = 1'b0, in_first = 1'b0;
  logic [7:0]  in_data = '0;
  logic        dec_valid, dec_accept, dec_group, dec_store, dec_missed;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  addr_filter i_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_cfg(rx_cfg), .station_addr(station_addr),
    .hash_table(hash_table), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_group(dec_group), .dec_store(dec_store), .dec_missed(dec_missed)
  );

  localparam logic [47:0] STA   = 48'h5544_3322_1102;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST = 48'h0100_005E_0001;

  // hash select: 0 empty, 1 only target bit, 2 all but target, 3 all ones
  typedef struct packed {
    logic [47:0] da;
    logic [5:0]  cfg;
    logic [1:0]  hsel;
    logic        acc;
    logic        sto;
    logic        mis;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{STA,                6'h04, 2'd0, 1'b1, 1'b1, 1'b0}, // R2 match
    '{48'h5644_3322_1102, 6'h04, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 last byte differs
    '{48'h5544_3322_1100, 6'h04, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 first byte differs
    '{BCAST,              6'h04, 2'd0, 1'b1, 1'b1, 1'b0}, // R3 enabled
    '{BCAST,              6'h08, 2'd3, 1'b0, 1'b0, 1'b0}, // R3 disabled, table full
    '{MCAST,              6'h08, 2'd1, 1'b1, 1'b1, 1'b0}, // R4 hit
    '{MCAST,              6'h08, 2'd2, 1'b0, 1'b0, 1'b0}, // R4 miss
    '{MCAST,              6'h04, 2'd3, 1'b0, 1'b0, 1'b0}, // R4 disabled
    '{48'h0000_0000_0A00, 6'h10, 2'd0, 1'b1, 1'b1, 1'b0}, // R5 unicast
    '{MCAST,              6'h10, 2'd0, 1'b1, 1'b1, 1'b0}, // R5 group
    '{STA,                6'h24, 2'd0, 1'b1, 1'b0, 1'b1}, // R7 monitor
    '{48'h0000_0000_0A00, 6'h23, 2'd0, 1'b0, 1'b0, 1'b0}, // R7/R8 reject
    '{STA,                6'h07, 2'd0, 1'b1, 1'b1, 1'b0}, // R8 extra bits
    '{MCAST,              6'h3F, 2'd2, 1'b1, 1'b0, 1'b1}  // R5/R7 prom+mon
  };

  function automatic logic [5:0] hash_index(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [5:0]  r;
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ da[8*b+k]) c = (c >> 1) ^ 32'hEDB8_8320;
        else                  c = c >> 1;
      end
    end
    for (int k = 0; k < 6; k++) r[k] = c[5-k];
    return r;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic send_bytes(input logic [47:0] da, input int first_at, input int nb);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (i == first_at);
      in_data  = da[8*i +: 8];
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [5:0] idx;
    logic       seen;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid in reset", dec_valid, 1'b0);
    check("R10 accept in reset", dec_accept, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 valid after release", dec_valid, 1'b0);
    check("R10 store after release", dec_store, 1'b0);

    for (int v = 0; v < NV; v++) begin
      idx = hash_index(VEC[v].da);
      case (VEC[v].hsel)
        2'd0: hash_table = '0;
        2'd1: hash_table = 64'd1 << idx;
        2'd2: hash_table = ~(64'd1 << idx);
        default: hash_table = '1;
      endcase
      rx_cfg = VEC[v].cfg;
      send_bytes(VEC[v].da, 0, 6);
      check("R1 pulse", dec_valid, 1'b1);
      check("R2/R3/R4/R5 accept", dec_accept, VEC[v].acc);
      check("R6 group", dec_group, VEC[v].da[0]);
      check("R7 store", dec_store, VEC[v].sto);
      check("R7 missed", dec_missed, VEC[v].mis);
      @(negedge clk);
      check("R1 single cycle", dec_valid, 1'b0);
    end

    // R9: restart in the middle of an address
    rx_cfg = 6'h04;
    hash_table = '0;
    send_bytes(48'h0000_0000_0000, 0, 3);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (i == 0);
      in_data  = STA[8*i +: 8];
      if (dec_valid) seen = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    check("R9 no early decision", seen, 1'b0);
    check("R9 restart decision", dec_valid, 1'b1);
    check("R9 restart accept", dec_accept, 1'b1);

    // R9: bare bytes after completion are ignored
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = 1'b0;
      in_data  = STA[8*(i%6) +: 8];
      if (dec_valid && i > 0) seen = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (dec_valid) seen = 1'b1;
    @(negedge clk);
    if (dec_valid) seen = 1'b1;
    check("R9 bare bytes ignored", seen, 1'b0);

    // R4: a group address other than the vector one, table bit by index
    rx_cfg = 6'h08;
    idx = hash_index(48'h3322_1100_5E01);
    hash_table = 64'd1 << idx;
    send_bytes(48'h3322_1100_5E01, 0, 6);
    check("R4 second group hit", dec_accept, 1'b1);
    check("R6 second group flag", dec_group, 1'b1);

    // R10: reset mid-address clears progress
    send_bytes(STA, 0, 3);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears output", dec_valid, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_bytes(STA, 99, 3);
    @(negedge clk);
    check("R10 no decision after reset", dec_valid, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule